// File: doc/BRIEF.md
# Dual-Style Parallel Host Register Port

This block is a synchronous slave that gives an external processor read and write access to a bank of internal 16-bit registers over a parallel bus. The host supplies the clock, and every input is sampled on its rising edge while the active-low reset is released. One input selects the bus style. With `bus_style` = 0 the host uses two separate active-low strobes, one for write and one for read. With `bus_style` = 1 it uses one direction line (1 = read, 0 = write) plus one active-low data strobe. Both styles share the same two pins. The port works only while `serial_sel` is low and `cs_n` is low.

Each access starts in ST_IDLE. When the port is enabled and a valid strobe is seen, the accept transition moves it to ST_BUSY, which drives `host_ready` low. After WAIT_CYC cycles the commit transition moves it to ST_HOLD. Commit performs the register write or loads the read-data holding register, and raises `host_ready` again. If the select drops while in ST_BUSY, the abort transition returns to ST_IDLE with no commit. From ST_HOLD, the release transition back to ST_IDLE happens only once `cs_n` goes high or `serial_sel` goes high, so each select cycle carries exactly one access.

The register at address 0xFE sets the data width: bit 0 set means 16-bit transfers, clear means 8-bit transfers. The data bus is modelled as separate input and output vectors with a per-bit output enable.

Top module: `hostport_top`

## Requirements
- R1: After reset every register reads as zero, the width is 8-bit, `host_ready` is 1 and `data_oe` is all zero.
- R2: With `bus_style`=0, `wr_n_dir`=0 with `rd_n_dstb`=1 is a write and `rd_n_dstb`=0 with `wr_n_dir`=1 is a read; both low starts no access and changes no register.
- R3: With `bus_style`=1, `rd_n_dstb`=0 starts an access that is a read when `wr_n_dir`=1 and a write when `wr_n_dir`=0.
- R4: No access starts while `cs_n`=1 or `serial_sel`=1: `host_ready` stays 1 and no register changes.
- R5: `host_ready` goes low on the first edge where select and a valid strobe are sampled together, stays low for exactly two cycles, then returns to 1.
- R6: After an access completes, `host_ready` stays 1 and no further access starts until `cs_n` has gone high, even if the strobe is still asserted.
- R7: When bit 0 of register 0xFE is 1, writes store all 16 data bits and reads return all 16 bits with `data_oe`=0xFFFF.
- R8: When bit 0 of register 0xFE is 0, writes change only bits 7:0 and keep bits 15:8. Reads return 0 on bits 15:8, and `data_oe`=0x00FF.
- R9: `data_oe` is non-zero only while `cs_n`=0, `serial_sel`=0 and a read is decoded. It is zero during writes and after `cs_n` rises.
- R10: Read data on `data_out` stays unchanged from the cycle `host_ready` returns to 1 until `cs_n` rises, even if `addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host-supplied clock; rising edge samples everything |
| host_rst_n | input | 1 | Active-low reset |
| serial_sel | input | 1 | High disables this port (serial port in use) |
| bus_style | input | 1 | 0 = separate strobes, 1 = direction plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 8 | Register address |
| wr_n_dir | input | 1 | Style 0: active-low write strobe; style 1: direction (1 read) |
| rd_n_dstb | input | 1 | Style 0: active-low read strobe; style 1: active-low data strobe |
| data_in | input | 16 | Write data from the host |
| data_out | output | 16 | Read data to the host |
| data_oe | output | 16 | Per-bit output enable for the data bus |
| host_ready | output | 1 | Low while an access is in progress |

## Verification
A wrong FSM state shows up as a `host_ready` low time other than two cycles, or as a second low pulse while `cs_n` stays low. Either is visible within three clocks of the strobe. A stale latched operation shows up as `data_oe` switching on during a write, or switching off before `cs_n` rises. A wrong lane-enable or width state leaves the register contents wrong. That only appears on the next read, so every write in the bench is followed by a read-back that scores the whole 16-bit word and its enable mask.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } hp_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } hp_op_e;

endpackage

// File: rtl/hp_strobe_decode.sv
module hp_strobe_decode
    import hp_pkg::*;
(
    input  logic   bus_style,
    input  logic   line_a,
    input  logic   line_b,
    output hp_op_e op
);

    always_comb begin
        op = OP_NONE;
        unique case (bus_style)
            1'b0: begin
                // separate active-low strobes; both low is not an access
                if (!line_a && line_b) begin
                    op = OP_WRITE;
                end else if (line_a && !line_b) begin
                    op = OP_READ;
                end
            end
            1'b1: begin
                // direction line plus active-low data strobe
                if (!line_b) begin
                    op = line_a ? OP_READ : OP_WRITE;
                end
            end
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/hp_handshake_fsm.sv
module hp_handshake_fsm
    import hp_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      cs_n,
    input  hp_op_e    op_now,
    output hp_state_e state,
    output logic      accept,
    output logic      commit,
    output logic      host_ready
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    hp_state_e        state_q;
    hp_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             sel_ok;

    assign sel_ok = enable && !cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_ok && op_now != OP_NONE) begin
                    state_d = ST_BUSY;
                    cnt_d   = '0;
                end
            end
            ST_BUSY: begin
                if (!sel_ok) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == LAST) begin
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (!sel_ok) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state      = state_q;
        accept     = (state_q == ST_IDLE) && (state_d == ST_BUSY);
        commit     = (state_q == ST_BUSY) && (state_d == ST_HOLD);
        host_ready = (state_q != ST_BUSY);
    end

endmodule

// File: rtl/hp_regfile.sv
module hp_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hFE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [DATA_W/8-1:0]      lane_we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        cfg_word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = DATA_W / 8;

    for (genvar l = 0; l < NB; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    lane_mem[i] <= '0;
                end
            end else if (we && lane_we[l]) begin
                lane_mem[waddr] <= wdata[l*8 +: 8];
            end
        end

        assign rdata[l*8 +: 8]    = lane_mem[raddr];
        assign cfg_word[l*8 +: 8] = lane_mem[CFG_ADDR];
    end

endmodule

// File: rtl/hostport_top.sv
module hostport_top
    import hp_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int WAIT_CYC = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hFE
) (
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              serial_sel,
    input  logic              bus_style,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n_dir,
    input  logic              rd_n_dstb,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] data_oe,
    output logic              host_ready
);

    localparam int NB = DATA_W / 8;

    logic              enable;
    hp_op_e            op_now;
    hp_state_e         fsm_state;
    logic              accept;
    logic              commit;
    hp_op_e            lat_op;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] rd_masked;
    logic [DATA_W-1:0] rd_hold;
    logic [NB-1:0]     lane_en;
    logic              wide_mode;
    logic              oe_active;

    assign enable    = !serial_sel;
    assign wide_mode = cfg_word[0];

    hp_strobe_decode u_decode (
        .bus_style (bus_style),
        .line_a    (wr_n_dir),
        .line_b    (rd_n_dstb),
        .op        (op_now)
    );

    hp_handshake_fsm #(
        .WAIT_CYC (WAIT_CYC)
    ) u_fsm (
        .clk        (host_clk),
        .rst_n      (host_rst_n),
        .enable     (enable),
        .cs_n       (cs_n),
        .op_now     (op_now),
        .state      (fsm_state),
        .accept     (accept),
        .commit     (commit),
        .host_ready (host_ready)
    );

    // capture the access when it is accepted
    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            lat_op    <= OP_NONE;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_op    <= op_now;
            lat_addr  <= addr;
            lat_wdata <= data_in;
        end
    end

    // byte lanes: lane 0 always, upper lanes only in wide mode
    assign lane_en[0] = 1'b1;
    for (genvar l = 1; l < NB; l++) begin : g_lane_en
        assign lane_en[l] = wide_mode;
    end

    hp_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_regs (
        .clk      (host_clk),
        .rst_n    (host_rst_n),
        .we       (commit && (lat_op == OP_WRITE)),
        .lane_we  (lane_en),
        .waddr    (lat_addr),
        .wdata    (lat_wdata),
        .raddr    (lat_addr),
        .rdata    (rdata),
        .cfg_word (cfg_word)
    );

    for (genvar l = 0; l < NB; l++) begin : g_rd_mask
        assign rd_masked[l*8 +: 8] = lane_en[l] ? rdata[l*8 +: 8] : 8'h00;
    end

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            rd_hold <= '0;
        end else if (commit && (lat_op == OP_READ)) begin
            rd_hold <= rd_masked;
        end
    end

    always_comb begin
        if (fsm_state == ST_IDLE) begin
            oe_active = enable && !cs_n && (op_now == OP_READ);
        end else begin
            oe_active = enable && !cs_n && (lat_op == OP_READ);
        end
    end

    for (genvar l = 0; l < NB; l++) begin : g_oe
        assign data_oe[l*8 +: 8] = {8{oe_active && lane_en[l]}};
    end

    assign data_out = rd_hold;

endmodule

// File: rtl/hp_checker.sv
module hp_checker
    import hp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              serial_sel,
    input logic              cs_n,
    input logic              host_ready,
    input logic [DATA_W-1:0] data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              wide,
    input hp_state_e         state
);

    assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |=> (!host_ready || cs_n || serial_sel));

    assert_ready_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && $past(!host_ready)) |=> host_ready);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        serial_sel |=> host_ready);

    assert_oe_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != '0) |-> (!cs_n && !serial_sel));

    assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (data_oe[DATA_W-1:8] == '0));

    assert_one_per_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !cs_n && !serial_sel) |=> host_ready);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && $past(host_ready) && !cs_n && $past(!cs_n)
         && (data_oe != '0) && ($past(data_oe) != '0)) |-> $stable(data_out));

endmodule

bind hostport_top hp_checker #(.DATA_W(DATA_W)) u_hp_checker (
    .clk        (host_clk),
    .rst_n      (host_rst_n),
    .serial_sel (serial_sel),
    .cs_n       (cs_n),
    .host_ready (host_ready),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .wide       (wide_mode),
    .state      (fsm_state)
);

// File: tb/hostport_top_tb_top.sv
module hostport_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serial_sel = 1'b0;
    logic        bus_style = 1'b0;
    logic        cs_n = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_n_dir = 1'b1;
    logic        rd_n_dstb = 1'b1;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic [15:0] data_oe;
    logic        host_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] q_data [$];
    logic [15:0] q_oe   [$];
    string       q_tag  [$];

    always #10 clk = ~clk;

    hostport_top dut_i (
        .host_clk   (clk),
        .host_rst_n (rst_n),
        .serial_sel (serial_sel),
        .bus_style  (bus_style),
        .cs_n       (cs_n),
        .addr       (addr),
        .wr_n_dir   (wr_n_dir),
        .rd_n_dstb  (rd_n_dstb),
        .data_in    (data_in),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .host_ready (host_ready)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: scores read results when ready returns high with the bus driven
    initial begin
        logic prev_rdy;
        prev_rdy = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!prev_rdy && host_ready && data_oe != '0) begin
                    if (q_data.size() == 0) begin
                        check(0, "R9", "unexpected read result", data_oe, 16'h0000);
                    end else begin
                        logic [15:0] ed;
                        logic [15:0] eo;
                        string       et;
                        ed = q_data.pop_front();
                        eo = q_oe.pop_front();
                        et = q_tag.pop_front();
                        check(data_out == ed, et, "read data", data_out, ed);
                        check(data_oe == eo, et, "read enable", data_oe, eo);
                    end
                end
                prev_rdy = host_ready;
            end
        end
    end

    // driver: one complete access, expected read result pushed to the scoreboard
    task automatic access(input logic style, input logic is_rd, input logic [7:0] a,
                          input logic [15:0] d, input logic [15:0] exp_d,
                          input logic [15:0] exp_oe, input int linger,
                          input logic [7:0] hold_addr, input string tag);
        int lows = 0;
        int lin_lows = 0;
        logic [15:0] at_rise;
        if (is_rd) begin
            q_data.push_back(exp_d);
            q_oe.push_back(exp_oe);
            q_tag.push_back(tag);
        end
        @(negedge clk);
        bus_style = style;
        addr      = a;
        data_in   = is_rd ? 16'h0000 : d;
        wr_n_dir  = is_rd;
        rd_n_dstb = (style == 1'b0) ? !is_rd : 1'b0;
        cs_n      = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!host_ready) begin
                lows++;
                if (!is_rd) check(data_oe == 16'h0000, "R9", "enable during write", data_oe, 16'h0000);
            end else if (lows > 0) begin
                break;
            end
        end
        check(lows == 2, "R5", "ready low cycles", 16'(lows), 16'd2);
        at_rise = data_out;
        #2;
        for (int i = 0; i < linger; i++) begin
            if (i == 0) addr = hold_addr;
            @(negedge clk);
            if (!host_ready) lin_lows++;
            if (is_rd) check(data_out == at_rise, "R10", "held read data", data_out, at_rise);
        end
        if (linger > 0) check(lin_lows == 0, "R6", "second access under one select", 16'(lin_lows), 16'd0);
        #2;
        cs_n      = 1'b1;
        wr_n_dir  = 1'b1;
        rd_n_dstb = 1'b1;
        #1;
        check(data_oe == 16'h0000, "R9", "enable after select release", data_oe, 16'h0000);
    endtask

    // stimulus that must not start an access
    task automatic probe_ignored(input logic style, input logic la, input logic lb,
                                 input logic cs_v, input logic ssel,
                                 input logic [7:0] a, input logic [15:0] d, input string tag);
        int lows = 0;
        @(negedge clk);
        bus_style  = style;
        addr       = a;
        data_in    = d;
        wr_n_dir   = la;
        rd_n_dstb  = lb;
        cs_n       = cs_v;
        serial_sel = ssel;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!host_ready) lows++;
        end
        check(lows == 0, tag, "ready low on ignored stimulus", 16'(lows), 16'd0);
        #2;
        cs_n       = 1'b1;
        wr_n_dir   = 1'b1;
        rd_n_dstb  = 1'b1;
        serial_sel = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready == 1'b1, "R1", "ready after reset", 16'(host_ready), 16'd1);
        check(data_oe == 16'h0000, "R1", "enable after reset", data_oe, 16'h0000);

        // reset contents, narrow width after reset
        access(0, 1, 8'h10, 16'h0, 16'h0000, 16'h00FF, 0, 8'h10, "R1");
        // select 16-bit width through bit 0 of 0xFE
        access(0, 0, 8'hFE, 16'h0001, 16'h0, 16'h0, 0, 8'hFE, "R7");
        access(0, 0, 8'h20, 16'hBEEF, 16'h0, 16'h0, 0, 8'h20, "R2");
        access(0, 1, 8'h20, 16'h0, 16'hBEEF, 16'hFFFF, 0, 8'h20, "R7");
        // direction plus data strobe style
        access(1, 0, 8'h31, 16'h1234, 16'h0, 16'h0, 0, 8'h31, "R3");
        access(1, 1, 8'h31, 16'h0, 16'h1234, 16'hFFFF, 0, 8'h31, "R3");
        // both separate strobes low: no access
        probe_ignored(0, 0, 0, 0, 0, 8'h20, 16'h0000, "R2");
        access(0, 1, 8'h20, 16'h0, 16'hBEEF, 16'hFFFF, 0, 8'h20, "R2");
        // serial mode selected: write ignored
        probe_ignored(0, 0, 1, 0, 1, 8'h20, 16'h0000, "R4");
        access(0, 1, 8'h20, 16'h0, 16'hBEEF, 16'hFFFF, 0, 8'h20, "R4");
        // chip select high: write ignored
        probe_ignored(1, 0, 0, 1, 0, 8'h20, 16'h0000, "R4");
        access(1, 1, 8'h20, 16'h0, 16'hBEEF, 16'hFFFF, 0, 8'h20, "R4");
        // strobe kept with select low, address moved during hold
        access(0, 1, 8'h31, 16'h0, 16'h1234, 16'hFFFF, 5, 8'h20, "R6");
        access(1, 0, 8'h31, 16'hAAAA, 16'h0, 16'h0, 4, 8'h31, "R6");
        access(1, 1, 8'h31, 16'h0, 16'hAAAA, 16'hFFFF, 0, 8'h31, "R6");
        // back to 8-bit width
        access(0, 0, 8'hFE, 16'h0000, 16'h0, 16'h0, 0, 8'hFE, "R8");
        access(0, 0, 8'h20, 16'h5577, 16'h0, 16'h0, 0, 8'h20, "R8");
        access(0, 1, 8'h20, 16'h0, 16'h0077, 16'h00FF, 0, 8'h20, "R8");
        access(1, 1, 8'h31, 16'h0, 16'h00AA, 16'h00FF, 3, 8'h20, "R10");
        access(0, 0, 8'hFE, 16'h0001, 16'h0, 16'h0, 0, 8'hFE, "R8");
        access(0, 1, 8'h20, 16'h0, 16'hBE77, 16'hFFFF, 0, 8'h20, "R8");

        repeat (3) @(negedge clk);
        check(q_data.size() == 0, "R9", "unscored reads left", 16'(q_data.size()), 16'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule